// File: doc/BRIEF.md
# Serial Programming Command Front End

This block is the target-side slave of a two-wire serial programming port. An external host toggles a programming clock pin and presents bits on a shared data pin. The block oversamples both pins with its own system clock, shifts in 6-bit command codes, and runs fixed 16-clock data frames for word loads and word reads. During a read frame it drives the data pin through an output enable, and it leaves the pin at high impedance outside that window.

A 14-bit address counter selects the word being worked on. Toward the memory side, the block issues single-cycle strobes: program-word write, data-byte write, program-word read and data-byte read. Each strobe is paired with the address and, for writes, the word. The erase-and-program, program-only and end-programming commands are not carried out here. Each one becomes a single-cycle strobe to a separate programming sequencer.

A command that enters configuration space moves the counter to 2000h and keeps it there until the active-low mode-exit input is taken low. Data-memory transfers carry a byte inside the 14-bit field. When the code-protect input is high, data reads return zero.

Top module: `pgm_cmd_front`

## Requirements
- R1: A command is 6 bits sampled on falling edges of the programming clock, least significant bit first. Codes are 00h load-configuration, 02h load-program, 03h load-data, 04h read-program, 05h read-data, 06h increment, 08h erase-and-program, 18h program-only and 17h end-programming. Any other code produces no strobe and leaves the address unchanged.
- R2: The increment command adds one to the address. In user space the address wraps from 1FFFh to 0000h, so it never leaves user space.
- R3: Load-configuration sets the address to 2000h and then runs a load frame whose word is written as a program word at 2000h. Afterwards, increments keep bit 13 of the address set.
- R4: While the mode-exit input is low, the address is 0000h, the configuration lock is cleared, any frame is abandoned and the output enable is low.
- R5: A load-program frame is 16 clocks long. Frame bit 0 is the start bit, bits 1 to 14 carry the word LSB first, and bit 15 is the stop bit. After the 16th falling edge exactly one program-write strobe is issued, carrying that word and the current address.
- R6: A load-data frame keeps only frame bits 1 to 8. It issues one data-write strobe whose word has bits 13:8 equal to zero.
- R7: In a read frame the output enable rises after the 2nd rising edge and falls after the 16th rising edge of the programming clock.
- R8: A read-program frame issues one program-read strobe and then drives the 14-bit word LSB first. Word bit k is driven from rising edge k+2, so the host samples it on falling edge k+2.
- R9: A read-data frame drives the low byte of the memory word with bits 13:8 as zero. With code-protect high it drives all zeros.
- R10: The erase-and-program, program-only and end-programming commands each raise their own sequencer strobe for one cycle.
- R11: At most one memory or sequencer strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclr_n | input | 1 | Active-low programming-mode exit; clears address and frame state |
| pgm_clk_i | input | 1 | Programming clock pin from the host |
| pgm_dat_i | input | 1 | Data pin input |
| pgm_dat_o | output | 1 | Data pin output value |
| pgm_dat_oe | output | 1 | Data pin output enable (high drives the pin) |
| mem_addr | output | 14 | Current address counter |
| mem_wdata | output | 14 | Word for the write strobes |
| mem_rdata | input | 14 | Word returned by memory, sampled the cycle after a read strobe |
| code_prot | input | 1 | Code protection active; data reads return zero |
| mem_wr_prog | output | 1 | Program-word write strobe |
| mem_wr_data | output | 1 | Data-byte write strobe |
| mem_rd_prog | output | 1 | Program-word read strobe |
| mem_rd_data | output | 1 | Data-byte read strobe |
| seq_erase_prog | output | 1 | Start erase-then-program cycle strobe |
| seq_prog_only | output | 1 | Start program-only cycle strobe |
| seq_prog_end | output | 1 | End programming strobe |

## Verification
Load frames are driven with walking-one and walking-zero words plus several mixed words. The walking patterns tell a bit misplaced by one frame position apart from a swapped byte. Data loads use words whose upper six bits are set, which exposes any leak of those bits. Reads are made at a sweep of addresses against a memory whose contents are computed from the address, each comparing the per-edge enable window and the serial bits. Data reads are repeated with code protection on and off. A run of increments, a set of unlisted codes, and a mode exit in the middle of a read frame while in configuration space separate counter stepping, ignored codes, and abort and lock release.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  localparam int CMD_W     = 6;
  localparam int WORD_W    = 14;
  localparam int BYTE_W    = 8;
  localparam int FRAME_LEN = 16;
  localparam int ADDR_W    = 14;
  localparam int SYNC_W    = 2;

  localparam logic [CMD_W-1:0] OP_LOAD_CFG  = 6'h00;
  localparam logic [CMD_W-1:0] OP_LOAD_PROG = 6'h02;
  localparam logic [CMD_W-1:0] OP_LOAD_DATA = 6'h03;
  localparam logic [CMD_W-1:0] OP_READ_PROG = 6'h04;
  localparam logic [CMD_W-1:0] OP_READ_DATA = 6'h05;
  localparam logic [CMD_W-1:0] OP_INC_ADDR  = 6'h06;
  localparam logic [CMD_W-1:0] OP_ERASE_PGM = 6'h08;
  localparam logic [CMD_W-1:0] OP_PGM_ONLY  = 6'h18;
  localparam logic [CMD_W-1:0] OP_PGM_END   = 6'h17;

  typedef enum logic [1:0] {ST_CMD, ST_LOAD, ST_READ} fe_state_t;
  typedef enum logic [1:0] {K_PROG, K_DATA, K_CFG} fe_kind_t;
endpackage

// File: rtl/pgm_pin_sync.sv
module pgm_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_pin,
  input  logic dat_pin,
  output logic rise,
  output logic fall,
  output logic dat
);
  logic [STAGES:0]   ck_q;
  logic [STAGES-1:0] dt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= '0;
      dt_q <= '0;
    end else begin
      ck_q <= {ck_q[STAGES-1:0], clk_pin};
      dt_q <= {dt_q[STAGES-2:0], dat_pin};
    end
  end

  assign rise = ck_q[STAGES-1] & ~ck_q[STAGES];
  assign fall = ~ck_q[STAGES-1] & ck_q[STAGES];
  assign dat  = dt_q[STAGES-1];
endmodule

// File: rtl/pgm_addr_ctr.sv
module pgm_addr_ctr #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic          jump_cfg,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] CFG_BASE = AW'(1) << (AW - 1);
  localparam logic [AW-2:0] ONE_LOW  = (AW-1)'(1);

  logic [AW-1:0] addr_q, addr_n;

  always_comb begin
    addr_n = addr_q;
    if (clr)           addr_n = '0;
    else if (jump_cfg) addr_n = CFG_BASE;
    else if (inc)      addr_n = {addr_q[AW-1], addr_q[AW-2:0] + ONE_LOW};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_n;
  end

  assign addr = addr_q;
endmodule

// File: rtl/pgm_frame_io.sv
module pgm_frame_io #(
  parameter int DW   = 14,
  parameter int FLEN = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic          rd_mode,
  input  logic          tx_load,
  input  logic [DW-1:0] tx_word,
  input  logic          rise,
  input  logic          fall,
  input  logic          din,
  output logic          done,
  output logic [DW-1:0] rx_word,
  output logic          dout,
  output logic          oe
);
  localparam int CW = $clog2(FLEN);
  localparam logic [CW-1:0] C_FIRST = CW'(1);
  localparam logic [CW-1:0] C_LAST  = CW'(FLEN - 1);

  logic            act_q, act_n, rdm_q, rdm_n;
  logic [CW-1:0]   rcnt_q, rcnt_n, fcnt_q, fcnt_n;
  logic [FLEN-1:0] rx_q, rx_n;
  logic [DW-1:0]   tx_q, tx_n;
  logic            oe_q, oe_n, do_q, do_n, dn_q, dn_n;

  always_comb begin
    act_n = act_q; rdm_n = rdm_q; rcnt_n = rcnt_q; fcnt_n = fcnt_q;
    rx_n = rx_q; tx_n = tx_q; oe_n = oe_q; do_n = do_q; dn_n = 1'b0;
    if (clr) begin
      act_n = 1'b0; rdm_n = 1'b0; rcnt_n = '0; fcnt_n = '0;
      rx_n = '0; tx_n = '0; oe_n = 1'b0; do_n = 1'b0;
    end else begin
      if (start) begin
        act_n = 1'b1; rdm_n = rd_mode; rcnt_n = '0; fcnt_n = '0;
      end
      if (tx_load) tx_n = tx_word;
      if (act_q && rise) begin
        rcnt_n = rcnt_q + C_FIRST;
        if (rdm_q) begin
          if (rcnt_q == C_FIRST) begin
            oe_n = 1'b1; do_n = tx_q[0]; tx_n = tx_q >> 1;
          end else if (rcnt_q == C_LAST) begin
            oe_n = 1'b0; do_n = 1'b0;
          end else if (oe_q) begin
            do_n = tx_q[0]; tx_n = tx_q >> 1;
          end
        end
      end
      if (act_q && fall) begin
        rx_n   = {din, rx_q[FLEN-1:1]};
        fcnt_n = fcnt_q + C_FIRST;
        if (fcnt_q == C_LAST) begin
          dn_n = 1'b1; act_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; rdm_q <= 1'b0; rcnt_q <= '0; fcnt_q <= '0;
      rx_q <= '0; tx_q <= '0; oe_q <= 1'b0; do_q <= 1'b0; dn_q <= 1'b0;
    end else begin
      act_q <= act_n; rdm_q <= rdm_n; rcnt_q <= rcnt_n; fcnt_q <= fcnt_n;
      rx_q <= rx_n; tx_q <= tx_n; oe_q <= oe_n; do_q <= do_n; dn_q <= dn_n;
    end
  end

  assign done    = dn_q;
  assign rx_word = rx_q[DW:1];
  assign dout    = do_q;
  assign oe      = oe_q;
endmodule

// File: rtl/pgm_cmd_front.sv
module pgm_cmd_front
  import pgm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr_n,
  input  logic              pgm_clk_i,
  input  logic              pgm_dat_i,
  output logic              pgm_dat_o,
  output logic              pgm_dat_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              code_prot,
  output logic              mem_wr_prog,
  output logic              mem_wr_data,
  output logic              mem_rd_prog,
  output logic              mem_rd_data,
  output logic              seq_erase_prog,
  output logic              seq_prog_only,
  output logic              seq_prog_end
);
  localparam int CCW = $clog2(CMD_W);
  localparam logic [CCW-1:0] CC_LAST = CCW'(CMD_W - 1);
  localparam logic [CCW-1:0] CC_ONE  = CCW'(1);
  localparam int PAD_W = WORD_W - BYTE_W;

  logic pin_rise, pin_fall, pin_dat;
  logic clr;
  assign clr = ~mclr_n;

  pgm_pin_sync #(.STAGES(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .clk_pin(pgm_clk_i), .dat_pin(pgm_dat_i),
    .rise(pin_rise), .fall(pin_fall), .dat(pin_dat)
  );

  fe_state_t          st_q, st_n;
  fe_kind_t           knd_q, knd_n;
  logic [CMD_W-1:0]   csh_q, csh_n, cmd_full;
  logic [CCW-1:0]     ccnt_q, ccnt_n;
  logic               inc, jump, start, rd_mode;
  logic               wp_n, wd_n, rp_n, rd_n, ep_n, po_n, pe_n;
  logic               wp_q, wd_q, rp_q, rd_q, ep_q, po_q, pe_q;
  logic               cap_q;
  logic [WORD_W-1:0]  wdat_q, wdat_n, tx_word;
  logic               f_done, f_dout, f_oe;
  logic [WORD_W-1:0]  rx_word;

  assign cmd_full = {pin_dat, csh_q[CMD_W-1:1]};

  always_comb begin
    st_n = st_q; knd_n = knd_q; csh_n = csh_q; ccnt_n = ccnt_q;
    inc = 1'b0; jump = 1'b0; start = 1'b0; rd_mode = 1'b0;
    wp_n = 1'b0; wd_n = 1'b0; rp_n = 1'b0; rd_n = 1'b0;
    ep_n = 1'b0; po_n = 1'b0; pe_n = 1'b0;
    wdat_n = wdat_q;
    if (clr) begin
      st_n = ST_CMD; knd_n = K_PROG; csh_n = '0; ccnt_n = '0;
    end else begin
      unique case (st_q)
        ST_CMD: if (pin_fall) begin
          if (ccnt_q == CC_LAST) begin
            ccnt_n = '0;
            csh_n  = '0;
            unique case (cmd_full)
              OP_LOAD_CFG:  begin jump = 1'b1; start = 1'b1; knd_n = K_CFG;  st_n = ST_LOAD; end
              OP_LOAD_PROG: begin start = 1'b1; knd_n = K_PROG; st_n = ST_LOAD; end
              OP_LOAD_DATA: begin start = 1'b1; knd_n = K_DATA; st_n = ST_LOAD; end
              OP_READ_PROG: begin start = 1'b1; rd_mode = 1'b1; rp_n = 1'b1; knd_n = K_PROG; st_n = ST_READ; end
              OP_READ_DATA: begin start = 1'b1; rd_mode = 1'b1; rd_n = 1'b1; knd_n = K_DATA; st_n = ST_READ; end
              OP_INC_ADDR:  inc  = 1'b1;
              OP_ERASE_PGM: ep_n = 1'b1;
              OP_PGM_ONLY:  po_n = 1'b1;
              OP_PGM_END:   pe_n = 1'b1;
              default: ;
            endcase
          end else begin
            ccnt_n = ccnt_q + CC_ONE;
            csh_n  = cmd_full;
          end
        end
        ST_LOAD: if (f_done) begin
          st_n = ST_CMD;
          if (knd_q == K_DATA) begin
            wd_n   = 1'b1;
            wdat_n = {{PAD_W{1'b0}}, rx_word[BYTE_W-1:0]};
          end else begin
            wp_n   = 1'b1;
            wdat_n = rx_word;
          end
        end
        ST_READ: if (f_done) st_n = ST_CMD;
        default: st_n = ST_CMD;
      endcase
    end
  end

  always_comb begin
    if (knd_q == K_DATA)
      tx_word = code_prot ? '0 : {{PAD_W{1'b0}}, mem_rdata[BYTE_W-1:0]};
    else
      tx_word = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_CMD; knd_q <= K_PROG; csh_q <= '0; ccnt_q <= '0;
      wp_q <= 1'b0; wd_q <= 1'b0; rp_q <= 1'b0; rd_q <= 1'b0;
      ep_q <= 1'b0; po_q <= 1'b0; pe_q <= 1'b0; cap_q <= 1'b0;
      wdat_q <= '0;
    end else begin
      st_q <= st_n; knd_q <= knd_n; csh_q <= csh_n; ccnt_q <= ccnt_n;
      wp_q <= wp_n; wd_q <= wd_n; rp_q <= rp_n; rd_q <= rd_n;
      ep_q <= ep_n; po_q <= po_n; pe_q <= pe_n;
      cap_q <= (rp_q | rd_q) & ~clr;
      wdat_q <= wdat_n;
    end
  end

  pgm_addr_ctr #(.AW(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .jump_cfg(jump),
    .addr(mem_addr)
  );

  pgm_frame_io #(.DW(WORD_W), .FLEN(FRAME_LEN)) u_frame (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .rd_mode(rd_mode),
    .tx_load(cap_q), .tx_word(tx_word), .rise(pin_rise), .fall(pin_fall),
    .din(pin_dat), .done(f_done), .rx_word(rx_word), .dout(f_dout), .oe(f_oe)
  );

  assign pgm_dat_o      = f_dout;
  assign pgm_dat_oe     = f_oe;
  assign mem_wdata      = wdat_q;
  assign mem_wr_prog    = wp_q;
  assign mem_wr_data    = wd_q;
  assign mem_rd_prog    = rp_q;
  assign mem_rd_data    = rd_q;
  assign seq_erase_prog = ep_q;
  assign seq_prog_only  = po_q;
  assign seq_prog_end   = pe_q;
endmodule

// File: rtl/pgm_cmd_front_chk.sv
module pgm_cmd_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mclr_n,
  input logic        pgm_dat_oe,
  input logic [13:0] mem_addr,
  input logic [13:0] mem_wdata,
  input logic        mem_wr_prog,
  input logic        mem_wr_data,
  input logic        mem_rd_prog,
  input logic        mem_rd_data,
  input logic        seq_erase_prog,
  input logic        seq_prog_only,
  input logic        seq_prog_end
);
  // R11: strobes are mutually exclusive
  p_strobe_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wr_prog, mem_wr_data, mem_rd_prog, mem_rd_data,
              seq_erase_prog, seq_prog_only, seq_prog_end}));

  // R3: once in configuration space the address stays there until mode exit
  p_cfg_lock_r3: assert property (@(posedge clk) disable iff (!rst_n || !mclr_n)
    mem_addr[13] |=> mem_addr[13]);

  // R4: mode exit clears the address and releases the data pin
  p_mclr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mclr_n |=> (mem_addr == 14'h0000 && !pgm_dat_oe));

  // R6: data-byte writes never carry upper bits
  p_data_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_data |-> (mem_wdata[13:8] == 6'h00));

  // R2: the address only steps by one, wraps within its space, or jumps to 2000h
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n || !mclr_n)
    ($past(mclr_n) && mem_addr != $past(mem_addr)) |->
      (mem_addr == $past(mem_addr) + 14'd1 || mem_addr == 14'h2000 ||
       mem_addr == 14'h0000));
endmodule

bind pgm_cmd_front pgm_cmd_front_chk u_pgm_cmd_front_chk (
  .clk(clk), .rst_n(rst_n), .mclr_n(mclr_n), .pgm_dat_oe(pgm_dat_oe),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr_prog(mem_wr_prog),
  .mem_wr_data(mem_wr_data), .mem_rd_prog(mem_rd_prog),
  .mem_rd_data(mem_rd_data), .seq_erase_prog(seq_erase_prog),
  .seq_prog_only(seq_prog_only), .seq_prog_end(seq_prog_end)
);

// File: tb/pgm_cmd_front_bench.sv
`timescale 1ns/1ps
module pgm_cmd_front_bench;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mclr_n = 1'b0;
  logic        pgm_clk_i = 1'b0;
  logic        pgm_dat_i = 1'b0;
  logic        code_prot = 1'b0;
  logic        pgm_dat_o, pgm_dat_oe;
  logic [13:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_wr_prog, mem_wr_data, mem_rd_prog, mem_rd_data;
  logic        seq_erase_prog, seq_prog_only, seq_prog_end;

  int n_chk = 0, n_bad = 0;
  int n_wp = 0, n_wd = 0, n_rp = 0, n_rd = 0, n_ep = 0, n_po = 0, n_pe = 0;
  logic [13:0] wp_addr, wp_word, wd_word;
  bit finished = 0;

  always #2.5 clk = ~clk;

  function automatic logic [13:0] mem_img(input logic [13:0] a);
    return (a * 14'd37) ^ 14'h1A5B;
  endfunction
  assign mem_rdata = mem_img(mem_addr);

  pgm_cmd_front u_pgm_cmd_front (
    .clk(clk), .rst_n(rst_n), .mclr_n(mclr_n), .pgm_clk_i(pgm_clk_i),
    .pgm_dat_i(pgm_dat_i), .pgm_dat_o(pgm_dat_o), .pgm_dat_oe(pgm_dat_oe),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .code_prot(code_prot), .mem_wr_prog(mem_wr_prog), .mem_wr_data(mem_wr_data),
    .mem_rd_prog(mem_rd_prog), .mem_rd_data(mem_rd_data),
    .seq_erase_prog(seq_erase_prog), .seq_prog_only(seq_prog_only),
    .seq_prog_end(seq_prog_end)
  );

  always @(negedge clk) begin
    if (mem_wr_prog) begin n_wp++; wp_addr = mem_addr; wp_word = mem_wdata; end
    if (mem_wr_data) begin n_wd++; wd_word = mem_wdata; end
    if (mem_rd_prog) n_rp++;
    if (mem_rd_data) n_rd++;
    if (seq_erase_prog) n_ep++;
    if (seq_prog_only) n_po++;
    if (seq_prog_end) n_pe++;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pin_bit(input logic b);
    pgm_dat_i = b; pgm_clk_i = 1'b1; tick(HALF);
    pgm_clk_i = 1'b0; tick(HALF);
  endtask

  task automatic send_cmd(input logic [5:0] c);
    for (int i = 0; i < 6; i++) pin_bit(c[i]);
  endtask

  task automatic load_frame(input logic [13:0] w);
    pin_bit(1'b0);
    for (int i = 0; i < 14; i++) pin_bit(w[i]);
    pin_bit(1'b0);
    tick(HALF);
  endtask

  task automatic read_frame(output logic [15:0] oe_v, output logic [13:0] dat_v);
    oe_v = '0; dat_v = '0;
    for (int k = 1; k <= 16; k++) begin
      pgm_dat_i = 1'b0; pgm_clk_i = 1'b1; tick(HALF);
      oe_v[k-1] = pgm_dat_oe;
      if (k >= 2 && k <= 15) dat_v[k-2] = pgm_dat_o;
      pgm_clk_i = 1'b0; tick(HALF);
    end
    tick(HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [13:0] ea, w, exp_w, dv;
    logic [15:0] ov;
    int c0, c1;
    tick(4); rst_n = 1'b1; tick(4); mclr_n = 1'b1; tick(4);

    // reset state (R4)
    check("R4 reset addr", mem_addr, 14'h0000);
    check("R4 reset oe", pgm_dat_oe, 1'b0);
    check("R11 no strobes at reset", n_wp + n_wd + n_rp + n_rd + n_ep + n_po + n_pe, 0);

    // R2: increment sweep
    ea = 14'h0000;
    for (int i = 0; i < 20; i++) begin
      send_cmd(6'h06); ea = ea + 14'd1;
      check("R2 increment", mem_addr, ea);
    end

    // R1: unlisted codes ignored
    c0 = n_wp + n_wd + n_rp + n_rd + n_ep + n_po + n_pe;
    foreach (ea[i]) ;
    send_cmd(6'h3F); send_cmd(6'h09); send_cmd(6'h01); send_cmd(6'h20);
    check("R1 unlisted code address", mem_addr, ea);
    check("R1 unlisted code strobes", n_wp + n_wd + n_rp + n_rd + n_ep + n_po + n_pe, c0);

    // R5: program loads, walking one and walking zero words
    for (int i = 0; i < 16; i++) begin
      if (i < 14) w = 14'd1 << i;
      else if (i == 14) w = 14'h2A55;
      else w = 14'h15AA;
      c0 = n_wp;
      send_cmd(6'h02); load_frame(w);
      check("R5 program write count", n_wp, c0 + 1);
      check("R5 program write word", wp_word, w);
      check("R5 program write addr", wp_addr, ea);
    end
    for (int i = 0; i < 14; i++) begin
      w = ~(14'd1 << i);
      send_cmd(6'h02); load_frame(w);
      check("R5 program write inverted word", wp_word, w);
    end

    // R6: data loads keep only the low byte
    for (int i = 0; i < 6; i++) begin
      w = 14'h3F00 | 14'((i * 53 + 7) & 8'hFF);
      c0 = n_wd; c1 = n_wp;
      send_cmd(6'h03); load_frame(w);
      check("R6 data write count", n_wd, c0 + 1);
      check("R6 data write word", wd_word, {6'h00, w[7:0]});
      check("R6 no program write", n_wp, c1);
    end

    // R7 R8: program reads over a sweep of addresses
    for (int i = 0; i < 6; i++) begin
      c0 = n_rp;
      send_cmd(6'h04); read_frame(ov, dv);
      check("R8 read strobe", n_rp, c0 + 1);
      check("R7 enable window", ov, 16'h7FFE);
      check("R8 program word", dv, mem_img(ea));
      check("R7 released after frame", pgm_dat_oe, 1'b0);
      send_cmd(6'h06); ea = ea + 14'd1;
    end

    // R9: data reads with and without protection
    for (int i = 0; i < 4; i++) begin
      code_prot = i[0];
      c0 = n_rd;
      send_cmd(6'h05); read_frame(ov, dv);
      exp_w = code_prot ? 14'h0000 : {6'h00, mem_img(ea)[7:0]};
      check("R9 data read strobe", n_rd, c0 + 1);
      check("R9 data read word", dv, exp_w);
      check("R7 data enable window", ov, 16'h7FFE);
      send_cmd(6'h06); ea = ea + 14'd1;
    end
    code_prot = 1'b0;

    // R10: sequencer strobes
    send_cmd(6'h08); check("R10 erase-program strobe", n_ep, 1);
    send_cmd(6'h18); check("R10 program-only strobe", n_po, 1);
    send_cmd(6'h17); check("R10 end strobe", n_pe, 1);
    check("R10 address kept", mem_addr, ea);

    // R3: configuration space
    c0 = n_wp;
    send_cmd(6'h00);
    check("R3 jump to config", mem_addr, 14'h2000);
    load_frame(14'h3A5C);
    check("R3 config write count", n_wp, c0 + 1);
    check("R3 config write addr", wp_addr, 14'h2000);
    check("R3 config write word", wp_word, 14'h3A5C);
    for (int i = 0; i < 7; i++) send_cmd(6'h06);
    check("R3 increment in config", mem_addr, 14'h2007);

    // R4: mode exit in the middle of a read frame
    send_cmd(6'h04);
    for (int k = 0; k < 3; k++) pin_bit(1'b0);
    pgm_clk_i = 1'b1; tick(HALF);
    check("R4 enable mid frame", pgm_dat_oe, 1'b1);
    mclr_n = 1'b0; tick(4);
    check("R4 exit clears oe", pgm_dat_oe, 1'b0);
    check("R4 exit clears addr", mem_addr, 14'h0000);
    pgm_clk_i = 1'b0; tick(HALF);
    mclr_n = 1'b1; tick(HALF);
    send_cmd(6'h06);
    check("R4 lock released", mem_addr, 14'h0001);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule